// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block collects the fundamental operating modes of a processor from a slow serial stream while the rest of the chip waits in reset. Once its own active-low reset is released, it derives a mode clock from the bus reference clock at one two-hundred-fifty-sixth of its frequency. It takes one stream bit per mode-clock rising edge, least significant bit first, until twenty bits have arrived.

After the last bit it raises a done flag, which the system uses to release the remaining logic from reset. From then on the captured word is frozen. The decoded settings hold until the next reset. These settings are the pipeline-to-bus clock ratio, the write address-to-data delay and the bus width.

The external storage that supplies the stream and the clock multiplier circuit that consumes the ratio are outside the block.

Top module: `boot_mode_loader`

## Requirements
- R1: While loading, `modeClk` has a period of 256 `clk` cycles. It is low for the first 128 cycles after reset release and high for the next 128, and it repeats that pattern.
- R2: Each stream bit on `modeIn` is captured at the `clk` edge on which `modeClk` rises. The n-th captured bit (counting from 0) becomes mode bit n, so stream order is least significant bit first.
- R3: `done` rises exactly one `clk` cycle after the edge that captures the twentieth bit. That is the 4993rd rising `clk` edge after reset release. `modeClk` stays low from the twentieth capture onward.
- R4: `writeDelay` equals mode bits 17:15 as an unsigned count of 0 to 7 cycles.
- R5: The multiplier code is mode bits 2:0. Codes 0 to 6 give `pllRatio` = code + 2 (2 to 8) with `multErr` low.
- R6: Multiplier code 7 is invalid. It gives `multErr` = 1 and `pllRatio` = 2.
- R7: `bus32` equals mode bit 8. A value of 0 selects a 64-bit bus and 1 selects a 32-bit bus.
- R8: Once `done` is high, `modeIn` is ignored. `done`, `pllRatio`, `writeDelay`, `bus32` and `multErr` hold until the next reset.
- R9: `rstN` low at any time clears `done` and holds `modeClk` low. Its release restarts loading from mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rstN | input | 1 | Active-low asynchronous reset; release starts loading |
| modeIn | input | 1 | Serial mode stream from external storage |
| modeClk | output | 1 | Divided clock for the serial source |
| done | output | 1 | High once all mode bits are loaded |
| pllRatio | output | 4 | Pipeline-to-bus clock ratio, 2 to 8 |
| writeDelay | output | 3 | Write address-to-data delay in cycles |
| bus32 | output | 1 | Bus width select, 1 = 32-bit |
| multErr | output | 1 | Invalid multiplier code was loaded |

## Verification
The bench targets the exact edge of every capture and of the done rise. A divider off by one, or a capture on the wrong mode-clock edge, would shift every field by one stream bit and raise done a cycle early or late.

Stream patterns surround each field with opposite fill bits. Decode taken from a neighbouring position would then read a wrong delay, ratio or width.

The invalid multiplier code is loaded to catch a design that passes 9 through as the ratio. After done, the stream keeps toggling to expose a register that keeps shifting.

One load is cut short by a reset, which exposes a design that resumes mid-stream instead of restarting at bit 0.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_FINISH = 2'd1,
    ST_DONE   = 2'd2
  } loadState_t;

  typedef struct packed {
    logic shiftEn;
    logic hold;
  } loadStrobes_t;

endpackage

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
  import boot_mode_pkg::*;
#(
  parameter int DIV_RATIO = 256,
  parameter int MODE_BITS = 20
) (
  input  logic         clk,
  input  logic         rstN,
  output loadStrobes_t strobes,
  output logic         modeClk,
  output logic         done
);

  localparam int DIV_W = $clog2(DIV_RATIO);
  localparam int HALF  = DIV_RATIO / 2;
  localparam int CNT_W = $clog2(MODE_BITS);

  loadState_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              captureNow;
  logic              lastBit;

  assign captureNow = (state == ST_LOAD) && (divCnt == DIV_W'(HALF - 1));
  assign lastBit    = (bitCnt == CNT_W'(MODE_BITS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_LOAD;
      divCnt <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (divCnt == DIV_W'(DIV_RATIO - 1)) divCnt <= '0;
          else                                 divCnt <= divCnt + 1'b1;
          if (captureNow) begin
            if (lastBit) state  <= ST_FINISH;
            else         bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_FINISH: state <= ST_DONE;
        default:   state <= ST_DONE;
      endcase
    end
  end

  assign strobes.shiftEn = captureNow;
  assign strobes.hold    = (state != ST_LOAD);
  assign modeClk         = (state == ST_LOAD) && (divCnt >= DIV_W'(HALF));
  assign done            = (state == ST_DONE);

endmodule

// File: rtl/boot_mode_dp.sv
module boot_mode_dp
  import boot_mode_pkg::*;
#(
  parameter int MODE_BITS = 20,
  parameter int MULT_LSB  = 0,
  parameter int DELAY_LSB = 15,
  parameter int WIDTH_BIT = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeIn,
  input  loadStrobes_t strobes,
  output logic [3:0]   pllRatio,
  output logic [2:0]   writeDelay,
  output logic         bus32,
  output logic         multErr
);

  localparam logic [2:0] MAX_CODE = 3'd6;

  logic [MODE_BITS-1:0] modeReg;
  logic [2:0]           multCode;
  logic                 unusedModeBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                modeReg <= '0;
    else if (strobes.shiftEn && !strobes.hold) modeReg <= {modeIn, modeReg[MODE_BITS-1:1]};
  end

  assign multCode   = modeReg[MULT_LSB +: 3];
  assign multErr    = (multCode > MAX_CODE);
  assign pllRatio   = multErr ? 4'd2 : ({1'b0, multCode} + 4'd2);
  assign writeDelay = modeReg[DELAY_LSB +: 3];
  assign bus32      = modeReg[WIDTH_BIT];

  assign unusedModeBits = ^modeReg;

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int DIV_RATIO = 256,
  parameter int MODE_BITS = 20,
  parameter int MULT_LSB  = 0,
  parameter int DELAY_LSB = 15,
  parameter int WIDTH_BIT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeIn,
  output logic       modeClk,
  output logic       done,
  output logic [3:0] pllRatio,
  output logic [2:0] writeDelay,
  output logic       bus32,
  output logic       multErr
);

  loadStrobes_t strobes;

  boot_mode_ctrl #(
    .DIV_RATIO(DIV_RATIO),
    .MODE_BITS(MODE_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .modeClk (modeClk),
    .done    (done)
  );

  boot_mode_dp #(
    .MODE_BITS(MODE_BITS),
    .MULT_LSB (MULT_LSB),
    .DELAY_LSB(DELAY_LSB),
    .WIDTH_BIT(WIDTH_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .modeIn     (modeIn),
    .strobes    (strobes),
    .pllRatio   (pllRatio),
    .writeDelay (writeDelay),
    .bus32      (bus32),
    .multErr    (multErr)
  );

endmodule

// File: rtl/boot_mode_loader_chk.sv
module boot_mode_loader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeClk,
  input logic       done,
  input logic [3:0] pllRatio,
  input logic [2:0] writeDelay,
  input logic       bus32,
  input logic       multErr
);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  p_clk_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !modeClk);

  p_fields_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> $stable({pllRatio, writeDelay, bus32, multErr}));

  p_ratio_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pllRatio >= 4'd2) && (pllRatio <= 4'd8));

  p_err_default_r6: assert property (@(posedge clk) disable iff (!rstN)
    multErr |-> (pllRatio == 4'd2));

  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |-> (!done && !modeClk));

endmodule

bind boot_mode_loader boot_mode_loader_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeClk    (modeClk),
  .done       (done),
  .pllRatio   (pllRatio),
  .writeDelay (writeDelay),
  .bus32      (bus32),
  .multErr    (multErr)
);

// File: tb/boot_mode_loader_bench.sv
module boot_mode_loader_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeIn = 1'b0;
  logic       modeClk, done, bus32, multErr;
  logic [3:0] pllRatio;
  logic [2:0] writeDelay;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  localparam int DONE_EDGE = 4993;

  always #4 clk = ~clk;

  boot_mode_loader u_boot_mode_loader (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .modeClk(modeClk), .done(done),
    .pllRatio(pllRatio), .writeDelay(writeDelay), .bus32(bus32), .multErr(multErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mkVec(input int code, input int dly, input int bw,
                                        input logic [19:0] fill);
    logic [19:0] v;
    v = fill;
    v[2:0]   = 3'(code);
    v[17:15] = 3'(dly);
    v[8]     = 1'(bw);
    return v;
  endfunction

  task automatic runLoad(input logic [19:0] vec, input int nCyc);
    int cyc;
    int idx;
    int code;
    int expRatio;
    @(negedge clk);
    rstN = 1'b0;
    modeIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 done in reset", int'(done), 0);
    chk("R9 modeClk in reset", int'(modeClk), 0);
    rstN = 1'b1;
    cyc = 0;
    for (int i = 0; i < nCyc; i++) begin
      idx = cyc >> 8;
      if (idx > 19) idx = 19;
      if (cyc < DONE_EDGE) modeIn = vec[idx];
      else                 modeIn = ~modeIn;
      @(negedge clk);
      cyc++;
      chk("R1/R3 modeClk", int'(modeClk), int'((cyc < DONE_EDGE - 1) && ((cyc % 256) >= 128)));
      chk("R3/R8 done", int'(done), int'(cyc >= DONE_EDGE));
    end
    if (cyc > DONE_EDGE) begin
      code = int'(vec[2:0]);
      expRatio = (code == 7) ? 2 : code + 2;
      chk("R4 writeDelay", int'(writeDelay), int'(vec[17:15]));
      chk("R5/R6 pllRatio", int'(pllRatio), expRatio);
      chk("R6 multErr", int'(multErr), int'(code == 7));
      chk("R7 bus32", int'(bus32), int'(vec[8]));
      chk("R2/R8 done held", int'(done), 1);
    end
  endtask

  initial begin
    runLoad(mkVec(3, 5, 1, 20'hA5C3E), 5400);
    runLoad(mkVec(1, 1, 1, 20'h12345), 2000);
    runLoad(mkVec(7, 2, 0, 20'h5F0F1), 5400);
    runLoad(mkVec(0, 0, 0, 20'hFFFFF), 5400);
    runLoad(mkVec(6, 7, 1, 20'h00000), 5400);
    runLoad(mkVec(4, 3, 0, 20'h3C96A), 5400);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule